// File: doc/BRIEF.md
# Heater Grid Excitation Controller

This block drives a rectangular grid of on-chip heater cells. A spatial power pattern is loaded into it, and the whole pattern is then switched on and off together as a slow square wave. Each cell owns a small control word, and the words are linked into one serial scan chain. A host loads the chain one bit per clock through a serial data input while a shift enable is high. A separate update strobe then copies the whole chain into a holding register in one step. As a result, the cell outputs never show a half-loaded pattern. The bit leaving the far end of the chain comes out on a pin, so a loaded pattern can be read back.

A divider on the reference clock produces a global excitation gate with a 50% duty cycle. The length of each half-period is a programmable cycle count, and a new count is adopted only when the gate changes phase. A DC mode holds the gate high. Every cell output is its decoded held value gated by this excitation signal.

A parameter selects one of two cell variants. In the bi-level variant, each cell has a single on/off bit, and the default grid is 10 x 10. In the multilevel variant, each cell holds a level code that turns on between one and four groups of oscillators, and the default grid is 6 x 6.

Top module: `heatgrid_excite`

## Requirements
- R1: While rst_n is low, gate, scan_out and every bit of cell_en are 0.
- R2: Each rising clock edge with scan_en high moves the chain by one place, and scan_in enters at cell 0. scan_out always shows the last chain bit. If the bits of a pattern are shifted in highest index first, a later shift of equal length reads that pattern back on scan_out in the same order.
- R3: The held pattern changes only on a clock edge with scan_upd high, where it takes the chain contents. Shifting alone leaves cell_en unchanged.
- R4: In the multilevel variant, cell i reads chain bits [3i+2:3i] as a level code. Its 4-bit output field cell_en[4i+3:4i] has bit j as the enable of oscillator group j. Code k from 1 to 4 sets the lowest k bits. Codes 0, 5, 6 and 7 give 0000.
- R5: In the bi-level variant, cell i reads chain bit i. cell_en[i] is that bit whenever the gate is high.
- R6: While gate is low, all cell_en bits are 0. While gate is high, cell_en equals the decoded held pattern.
- R7: With dc_mode low, gate is a square wave whose high and low phases each last H clock cycles. H is the half-period count in force for that phase.
- R8: half_period is sampled only at the clock edge that starts a new phase, and in DC mode. A change in the middle of a phase does not alter that phase's length.
- R9: A half_period value of 0 is treated as 1, which makes gate toggle on every clock.
- R10: gate is high from the first clock edge after dc_mode is sampled high and stays high while dc_mode stays high. After dc_mode is sampled low, gate falls on the H-th clock edge, where H is the value last sampled during DC mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial pattern data into cell 0 |
| scan_en | input | 1 | Shift the chain one place per clock |
| scan_upd | input | 1 | Copy the chain into the holding register |
| dc_mode | input | 1 | Hold the excitation gate high |
| half_period | input | HP_W | Half-period of the square wave in clock cycles |
| scan_out | output | 1 | Last bit of the chain |
| gate | output | 1 | Global excitation gate |
| cell_en | output | CELLS*OW | Per-cell enable fields (OW = 4 in the multilevel variant, 1 in the bi-level variant) |

## Verification
The assertions assume that clk runs freely and that dc_mode, scan_en and scan_upd change only between clock edges. They also assume that no update is issued in the same cycle as a shift whose result is expected in the holding register. The stimulus keeps to these assumptions. It drives every input on the falling edge and ends each shift burst before it pulses the update strobe. It holds half-period values small, so that the full lengths of several phases can be observed.

// File: rtl/heatgrid_pkg.sv
`timescale 1ns/1ps
package heatgrid_pkg;
    localparam int LVL_W = 3;
    localparam int GRP_W = 4;

    // level code to thermometer group enables; unused codes are off
    function automatic logic [GRP_W-1:0] lvl_groups(input logic [LVL_W-1:0] code);
        logic [GRP_W-1:0] g;
        case (code)
            3'd1:    g = 4'b0001;
            3'd2:    g = 4'b0011;
            3'd3:    g = 4'b0111;
            3'd4:    g = 4'b1111;
            default: g = 4'b0000;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/heat_scan_chain.sv
`timescale 1ns/1ps
module heat_scan_chain #(
    parameter int LEN = 108
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           ser_in,
    input  logic           upd,
    output logic           ser_out,
    output logic [LEN-1:0] held
);
    typedef struct packed {
        logic [LEN-1:0] sh;
        logic [LEN-1:0] hold;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.sh = {st_q.sh[LEN-2:0], ser_in};
        if (upd)      st_d.hold = st_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_out = st_q.sh[LEN-1];
    assign held    = st_q.hold;

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.hold));

    // R2
    shift_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.sh));
endmodule

// File: rtl/heat_excite_div.sv
`timescale 1ns/1ps
module heat_excite_div #(
    parameter int HP_W     = 24,
    parameter int DEF_HALF = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dc_mode,
    input  logic [HP_W-1:0] half_in,
    output logic            gate
);
    typedef struct packed {
        logic [HP_W-1:0] cnt;
        logic [HP_W-1:0] half;
        logic            gate;
    } div_t;

    div_t st_d, st_q;
    logic [HP_W-1:0] half_ok;

    always_comb begin
        half_ok = (half_in == '0) ? HP_W'(1) : half_in;
        st_d = st_q;
        if (dc_mode) begin
            st_d.gate = 1'b1;
            st_d.cnt  = '0;
            st_d.half = half_ok;
        end else if (st_q.cnt == st_q.half - HP_W'(1)) begin
            st_d.gate = ~st_q.gate;
            st_d.cnt  = '0;
            st_d.half = half_ok;
        end else begin
            st_d.cnt = st_q.cnt + HP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.half <= HP_W'(DEF_HALF);
            st_q.gate <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate = st_q.gate;

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.half);

    // R9
    half_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.half != '0);

    // R8
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(dc_mode) && st_q.cnt != '0) |-> st_q.half == $past(st_q.half));

    // R10
    dc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_mode |=> st_q.gate);
endmodule

// File: rtl/heat_cell_decode.sv
`timescale 1ns/1ps
module heat_cell_decode
    import heatgrid_pkg::*;
#(
    parameter int CELLS = 36,
    parameter bit MULTI = 1'b1,
    parameter int CW    = 3,
    parameter int OW    = 4
) (
    input  logic [CELLS*CW-1:0] held,
    input  logic                gate,
    output logic [CELLS*OW-1:0] en
);
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        if (MULTI) begin : g_multi
            assign en[i*OW +: OW] = gate ? lvl_groups(held[i*CW +: LVL_W]) : '0;
        end else begin : g_bi
            assign en[i*OW +: OW] = held[i*CW +: CW] & {OW{gate}};
        end
    end
endmodule

// File: rtl/heatgrid_excite.sv
`timescale 1ns/1ps
module heatgrid_excite
    import heatgrid_pkg::*;
#(
    parameter int ROWS     = 6,
    parameter int COLS     = 6,
    parameter bit MULTI    = 1'b1,
    parameter int HP_W     = 24,
    parameter int DEF_HALF = 4,
    localparam int CELLS   = ROWS * COLS,
    localparam int CW      = MULTI ? LVL_W : 1,
    localparam int OW      = MULTI ? GRP_W : 1,
    localparam int LEN     = CELLS * CW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_in,
    input  logic                scan_en,
    input  logic                scan_upd,
    input  logic                dc_mode,
    input  logic [HP_W-1:0]     half_period,
    output logic                scan_out,
    output logic                gate,
    output logic [CELLS*OW-1:0] cell_en
);
    logic [LEN-1:0] held_w;
    logic           gate_w;

    heat_scan_chain #(.LEN(LEN)) u_chain (
        .clk(clk), .rst_n(rst_n), .shift_en(scan_en), .ser_in(scan_in),
        .upd(scan_upd), .ser_out(scan_out), .held(held_w)
    );

    heat_excite_div #(.HP_W(HP_W), .DEF_HALF(DEF_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .dc_mode(dc_mode), .half_in(half_period),
        .gate(gate_w)
    );

    heat_cell_decode #(.CELLS(CELLS), .MULTI(MULTI), .CW(CW), .OW(OW)) u_dec (
        .held(held_w), .gate(gate_w), .en(cell_en)
    );

    assign gate = gate_w;

    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> cell_en == '0);

    if (MULTI) begin : g_thermo
        for (genvar i = 0; i < CELLS; i++) begin : g_c
            // R4
            thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (({1'b0, cell_en[i*OW +: OW]} + 5'd1) & {1'b0, cell_en[i*OW +: OW]}) == 5'd0);
        end
    end
endmodule

// File: tb/sim_heatgrid_excite.sv
`timescale 1ns/1ps
module sim_heatgrid_excite;
    localparam int CELLS = 36;
    localparam int LEN   = 108;
    localparam int OW    = 4;
    localparam int BN    = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic scan_in0 = 0, scan_en0 = 0, upd0 = 0;
    logic scan_in1 = 0, scan_en1 = 0, upd1 = 0;
    logic dc_mode = 0;
    logic [23:0] half_in = 24'd5;
    logic so0, g0, so1, g1;
    logic [CELLS*OW-1:0] en0;
    logic [BN-1:0] en1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    heatgrid_excite u0 (
        .clk(clk), .rst_n(rst_n), .scan_in(scan_in0), .scan_en(scan_en0),
        .scan_upd(upd0), .dc_mode(dc_mode), .half_period(half_in),
        .scan_out(so0), .gate(g0), .cell_en(en0)
    );

    heatgrid_excite #(.ROWS(10), .COLS(10), .MULTI(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .scan_in(scan_in1), .scan_en(scan_en1),
        .scan_upd(upd1), .dc_mode(dc_mode), .half_period(half_in),
        .scan_out(so1), .gate(g1), .cell_en(en1)
    );

    task automatic chk(input string req, input logic [199:0] act, input logic [199:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_grp(input logic [2:0] c);
        case (c)
            3'd1: return 4'b0001;
            3'd2: return 4'b0011;
            3'd3: return 4'b0111;
            3'd4: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [CELLS*OW-1:0] exp_cells(input logic [LEN-1:0] p);
        logic [CELLS*OW-1:0] r;
        for (int i = 0; i < CELLS; i++) r[i*OW +: OW] = exp_grp(p[i*3 +: 3]);
        return r;
    endfunction

    task automatic load0(input logic [LEN-1:0] p, input logic [LEN-1:0] prev, output int mism);
        mism = 0;
        for (int k = LEN - 1; k >= 0; k--) begin
            @(negedge clk);
            if (so0 !== prev[k]) mism++;
            scan_in0 = p[k];
            scan_en0 = 1'b1;
        end
        @(negedge clk);
        scan_en0 = 1'b0;
    endtask

    task automatic load1(input logic [BN-1:0] p, input logic [BN-1:0] prev, output int mism);
        mism = 0;
        for (int k = BN - 1; k >= 0; k--) begin
            @(negedge clk);
            if (so1 !== prev[k]) mism++;
            scan_in1 = p[k];
            scan_en1 = 1'b1;
        end
        @(negedge clk);
        scan_en1 = 1'b0;
    endtask

    task automatic pulse_upd0();
        @(negedge clk); upd0 = 1'b1;
        @(negedge clk); upd0 = 1'b0;
    endtask

    task automatic pulse_upd1();
        @(negedge clk); upd1 = 1'b1;
        @(negedge clk); upd1 = 1'b0;
    endtask

    // called on the first negedge of a phase; returns on the first negedge of the next
    task automatic measure(output int len);
        logic v;
        v = g0;
        len = 1;
        for (int t = 0; t < 1000; t++) begin
            @(negedge clk);
            if (g0 !== v) break;
            len++;
        end
    endtask

    task automatic wait_toggle();
        logic v;
        v = g0;
        for (int t = 0; t < 1000; t++) begin
            @(negedge clk);
            if (g0 !== v) break;
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int len, mism, hi;
        logic [LEN-1:0] pat, prev_sh, prev_hold;
        logic [BN-1:0] bp, bprev;
        void'($urandom(32'd20250));
        prev_sh = '0; prev_hold = '0; bprev = '0;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 gate", {199'd0, g0}, 200'd0);
        chk("R1 cell_en", {56'd0, en0}, 200'd0);
        chk("R1 scan_out", {198'd0, so0, so1}, 200'd0);
        rst_n = 1'b1;

        // R7: first low phase uses the reset count, then 5 is adopted
        wait_toggle();
        measure(len); chk("R7 high phase", 200'(len), 200'd5);
        measure(len); chk("R7 low phase", 200'(len), 200'd5);
        // R8: change in mid-phase only acts at the next boundary
        half_in = 24'd9;
        measure(len); chk("R8 current phase", 200'(len), 200'd5);
        measure(len); chk("R8 next phase", 200'(len), 200'd9);
        // R9: zero behaves as one
        half_in = 24'd0;
        measure(len); chk("R9 old phase", 200'(len), 200'd9);
        measure(len); chk("R9 phase a", 200'(len), 200'd1);
        measure(len); chk("R9 phase b", 200'(len), 200'd1);
        half_in = 24'd3;

        // R10 DC mode
        @(negedge clk); dc_mode = 1'b1;
        @(negedge clk); chk("R10 dc gate on", {199'd0, g0}, 200'd1);
        hi = 0;
        repeat (6) begin @(negedge clk); if (g0 === 1'b1) hi++; end
        chk("R10 dc gate held", 200'(hi), 200'd6);

        // multilevel patterns: directed (all codes) then random
        for (int it = 0; it < 6; it++) begin
            for (int c = 0; c < CELLS; c++)
                pat[c*3 +: 3] = (it == 0) ? 3'(c % 8) : 3'($urandom % 8);
            load0(pat, prev_sh, mism);
            chk("R2 readback", 200'(mism), 200'd0);
            chk("R3 no change before update", {56'd0, en0}, {56'd0, exp_cells(prev_hold)});
            pulse_upd0();
            chk("R4 decoded levels", {56'd0, en0}, {56'd0, exp_cells(pat)});
            prev_sh = pat; prev_hold = pat;
        end

        // R10 release then R6 gating
        @(negedge clk); dc_mode = 1'b0;
        hi = 0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (g0 !== 1'b1) break;
            hi++;
        end
        chk("R10 release high count", 200'(hi), 200'd2);
        chk("R6 gate low forces zero", {56'd0, en0}, 200'd0);
        wait_toggle();
        chk("R6 gate high shows pattern", {56'd0, en0}, {56'd0, exp_cells(prev_hold)});

        // bi-level variant
        @(negedge clk); dc_mode = 1'b1;
        for (int it = 0; it < 3; it++) begin
            for (int b = 0; b < BN; b++) bp[b] = 1'($urandom % 2);
            if (it == 0) bp = {BN{1'b1}};
            load1(bp, bprev, mism);
            chk("R2 bi-level readback", 200'(mism), 200'd0);
            pulse_upd1();
            chk("R5 bi-level enables", {100'd0, en1}, {100'd0, bp});
            bprev = bp;
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1;
        $finish;
    end
endmodule